// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's data port. It gives that processor an atomic read-modify-write that needs no bus lock. A load-linked reads a word and arms a reservation on the cache line that holds that word. A later store-conditional reaches memory only while the reservation is still armed and covers the same line. The processor gets back a pass or fail flag and retries in software when the flag is clear.

The reservation is disarmed in four ways. A write by another agent to the reserved line, seen on any of the snoop channels, disarms it. A local eviction of the reserved line disarms it. Every store-conditional disarms it, whatever its outcome. A newer load-linked replaces it. Other operations may run between the two halves of the pair. Plain loads and stores pass straight through to the cache port.

Every request gets one response on the cycle after it is accepted. Read data comes from a synchronous cache port that returns the word one cycle after the read strobe. The cache array and the coherence logic sit outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held, `rsp_valid` is low and `mem_we` is low.
- R2: Every accepted request raises `rsp_valid` exactly one cycle later. For a plain load (`req_op`=0) or a load-linked (`req_op`=2), `rsp_data` then equals the word held at `req_addr`.
- R3: A plain store (`req_op`=1) asserts `mem_we` in the request cycle. It has no effect on the reservation, even when it targets the reserved line.
- R4: A load-linked arms the reservation on the line of `req_addr`. The line is the address with its low log2(LINE_BYTES) bits ignored. A newer load-linked replaces any older reservation.
- R5: A store-conditional (`req_op`=3) asserts `mem_we` in its request cycle only when an armed reservation covers its line. The following response carries `rsp_sc_ok`=1 in that case and 0 otherwise, with no write.
- R6: Every store-conditional disarms the reservation, whether it passes or fails.
- R7: A snooped write on any channel to the reserved line disarms the reservation. Snooped writes to other lines leave it armed.
- R8: A local eviction of the reserved line disarms the reservation. Evictions of other lines leave it armed.
- R9: When a snooped write or an eviction hits the reserved line in the same cycle as a store-conditional to that line, the store-conditional fails and `mem_we` stays low.
- R10: When a snooped write or an eviction hits the line of a load-linked in its request cycle, the load-linked returns its data but arms no reservation.
- R11: The responses to stores and store-conditionals carry `rsp_data`=0. Every response to a request other than a store-conditional carries `rsp_sc_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| mem_re | output | 1 | Read strobe to the cache port |
| mem_we | output | 1 | Gated write strobe to the cache port |
| mem_addr | output | ADDR_W | Cache port address |
| mem_wdata | output | DATA_W | Cache port write data |
| mem_rdata | input | DATA_W | Cache read data, one cycle after `mem_re` |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_data | output | DATA_W | Read data for loads, zero otherwise |
| rsp_sc_ok | output | 1 | Store-conditional passed |
| snp_valid | input | NUM_SNP | Write by another agent, one bit per channel |
| snp_addr | input | NUM_SNP*ADDR_W | Snooped write addresses, channel 0 in the low bits |
| evict_valid | input | 1 | Local line eviction this cycle |
| evict_addr | input | ADDR_W | Address inside the evicted line |

## Verification
The bench targets the same-cycle races, where a snooped write or an eviction lands on the reserved line together with a store-conditional or a load-linked. A design that gives the local request priority would let a conditional store through or leave a stale reservation armed. It also probes line granularity by reserving one word and storing to a neighbour in the same line. A design that compares full addresses would fail that pair and would also ignore snoops to neighbouring words. The remaining cases are a failed store-conditional, which must still disarm the reservation, and a second load-linked, which must replace the first. A monitor that kept either old reservation would report a pass where the bench expects a fail.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } mem_op_e;

endpackage

// File: rtl/llsc_line_match.sv
// Line-granular address comparator: low offset bits are ignored.
module llsc_line_match #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              a_valid,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_valid,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              hit
);
    localparam int OFS = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0;

    logic [ADDR_W-1:0] a_line;
    logic [ADDR_W-1:0] b_line;

    always_comb begin
        a_line = a_addr >> OFS;
        b_line = b_addr >> OFS;
        hit    = a_valid && b_valid && (a_line == b_line);
    end
endmodule

// File: rtl/llsc_kill_unit.sv
// Collects every snoop channel and the eviction port into two kill terms:
// one against the held reservation, one against the line of the current request.
module llsc_kill_unit #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_SNP    = 2
) (
    input  logic                      rsv_valid,
    input  logic [ADDR_W-1:0]         rsv_addr,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [NUM_SNP-1:0]        snp_valid,
    input  logic [NUM_SNP*ADDR_W-1:0] snp_addr,
    input  logic                      evict_valid,
    input  logic [ADDR_W-1:0]         evict_addr,
    output logic                      kill_rsv,
    output logic                      kill_req
);
    localparam int SRC = NUM_SNP + 1;

    logic [SRC-1:0]        src_valid;
    logic [SRC*ADDR_W-1:0] src_addr;
    logic [SRC-1:0]        hit_rsv;
    logic [SRC-1:0]        hit_req;

    always_comb begin
        src_valid = {evict_valid, snp_valid};
        src_addr  = {evict_addr, snp_addr};
    end

    for (genvar i = 0; i < SRC; i++) begin : g_src
        llsc_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_rsv_cmp (
            .a_valid (src_valid[i]),
            .a_addr  (src_addr[i*ADDR_W +: ADDR_W]),
            .b_valid (rsv_valid),
            .b_addr  (rsv_addr),
            .hit     (hit_rsv[i])
        );
        llsc_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_req_cmp (
            .a_valid (src_valid[i]),
            .a_addr  (src_addr[i*ADDR_W +: ADDR_W]),
            .b_valid (req_valid),
            .b_addr  (req_addr),
            .hit     (hit_req[i])
        );
    end

    always_comb begin
        kill_rsv = |hit_rsv;
        kill_req = |hit_req;
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_SNP    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      mem_re,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      rsp_sc_ok,
    input  logic [NUM_SNP-1:0]        snp_valid,
    input  logic [NUM_SNP*ADDR_W-1:0] snp_addr,
    input  logic                      evict_valid,
    input  logic [ADDR_W-1:0]         evict_addr
);
    import llsc_pkg::*;

    typedef struct packed {
        logic              rsv_valid;
        logic [ADDR_W-1:0] rsv_addr;
        logic              rsp_valid;
        logic              rd_pend;
        logic              sc_ok;
    } state_t;

    state_t st_d, st_q;

    mem_op_e op;
    logic    is_load, is_store, is_link, is_cond;
    logic    sc_line_hit, sc_pass;
    logic    kill_rsv, kill_req;

    llsc_kill_unit #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_SNP(NUM_SNP)
    ) u_kill (
        .rsv_valid   (st_q.rsv_valid),
        .rsv_addr    (st_q.rsv_addr),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .snp_valid   (snp_valid),
        .snp_addr    (snp_addr),
        .evict_valid (evict_valid),
        .evict_addr  (evict_addr),
        .kill_rsv    (kill_rsv),
        .kill_req    (kill_req)
    );

    llsc_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_sc_cmp (
        .a_valid (st_q.rsv_valid),
        .a_addr  (st_q.rsv_addr),
        .b_valid (req_valid),
        .b_addr  (req_addr),
        .hit     (sc_line_hit)
    );

    always_comb begin
        op       = mem_op_e'(req_op);
        is_load  = req_valid && (op == OP_LOAD);
        is_store = req_valid && (op == OP_STORE);
        is_link  = req_valid && (op == OP_LINK);
        is_cond  = req_valid && (op == OP_COND);
        // a coinciding snoop or eviction wins over the local conditional store
        sc_pass  = is_cond && sc_line_hit && !kill_rsv;

        mem_re    = is_load || is_link;
        mem_we    = is_store || sc_pass;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rd_pend   = is_load || is_link;
        st_d.sc_ok     = sc_pass;

        if (kill_rsv || is_cond) begin
            st_d.rsv_valid = 1'b0;
        end
        if (is_link) begin
            st_d.rsv_valid = !kill_req;
            st_d.rsv_addr  = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rsp_valid = st_q.rsp_valid;
        rsp_data  = st_q.rd_pend ? mem_rdata : '0;
        rsp_sc_ok = st_q.sc_ok;
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       mem_we,
    input logic       rsp_valid,
    input logic       rsp_sc_ok,
    input logic       rsv_valid,
    input logic       kill_rsv,
    input logic       kill_req
);
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_link_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && !kill_req) |=> rsv_valid);

    assert_cond_needs_rsv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && mem_we) |-> rsv_valid);

    assert_cond_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> !rsv_valid);

    assert_snoop_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_rsv && !(req_valid && req_op == 2'd2)) |=> !rsv_valid);

    assert_race_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && kill_rsv) |-> !mem_we);

    assert_link_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && kill_req) |=> !rsv_valid);

    assert_ok_only_cond_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd3) |=> !rsp_sc_ok);
endmodule

bind llsc_monitor llsc_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .mem_we    (mem_we),
    .rsp_valid (rsp_valid),
    .rsp_sc_ok (rsp_sc_ok),
    .rsv_valid (st_q.rsv_valid),
    .kill_rsv  (kill_rsv),
    .kill_req  (kill_req)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NS = 2;

    typedef struct {
        logic [DW-1:0] data;
        logic          ok;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_sc_ok;
    logic [NS-1:0] snp_valid = '0;
    logic [NS*AW-1:0] snp_addr = '0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t sb[$];
    logic [DW-1:0] mem [64];

    always #2 clk = ~clk;

    llsc_monitor u_dut (.*);

    initial for (int i = 0; i < 64; i++) mem[i] = 32'h1000 + i;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:2]];
    end

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R2: response with no request, got data=%h ok=%b expected none",
                         rsp_data, rsp_sc_ok);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_data !== e.data || rsp_sc_ok !== e.ok) begin
                    n_bad++;
                    $display("FAIL %s: got data=%h ok=%b, expected data=%h ok=%b",
                             e.tag, rsp_data, rsp_sc_ok, e.data, e.ok);
                end
            end
        end
    end

    task automatic step(input bit rv, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [NS-1:0] smask,
                        input logic [AW-1:0] sa, input bit ev, input logic [AW-1:0] ea,
                        input logic [DW-1:0] xd, input bit xok, input bit xwe,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_valid   = rv;
        req_op      = op;
        req_addr    = a;
        req_wdata   = wd;
        snp_valid   = smask;
        snp_addr    = {sa, sa};
        evict_valid = ev;
        evict_addr  = ea;
        if (rv) begin
            e.data = xd; e.ok = xok; e.tag = tag;
            sb.push_back(e);
        end
        #1;
        n_chk++;
        if (mem_we !== xwe) begin
            n_bad++;
            $display("FAIL %s: got mem_we=%b, expected mem_we=%b", tag, mem_we, xwe);
        end
    endtask

    task automatic rq(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] xd, input bit xok, input bit xwe, input string tag);
        step(1'b1, op, a, wd, '0, '0, 1'b0, '0, xd, xok, xwe, tag);
    endtask

    task automatic idle_snoop(input logic [NS-1:0] smask, input logic [AW-1:0] sa,
                              input bit ev, input logic [AW-1:0] ea, input string tag);
        step(1'b0, 2'd0, '0, '0, smask, sa, ev, ea, '0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || mem_we !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got rsp_valid=%b mem_we=%b, expected 0 0", rsp_valid, mem_we);
        end
        rst_n = 1'b1;

        // op codes: 0 load, 1 store, 2 load-linked, 3 store-conditional
        rq(2'd3, 32'h40, 32'hAAAA, 32'h0, 1'b0, 1'b0, "R1 no reservation after reset");
        rq(2'd1, 32'h48, 32'h5555, 32'h0, 1'b0, 1'b1, "R3 store writes");
        rq(2'd0, 32'h48, 32'h0, 32'h5555, 1'b0, 1'b0, "R2 load returns stored word");
        rq(2'd2, 32'h40, 32'h0, 32'h1010, 1'b0, 1'b0, "R2 load-linked data");
        rq(2'd3, 32'h40, 32'h1111, 32'h0, 1'b1, 1'b1, "R5 conditional passes");
        rq(2'd0, 32'h40, 32'h0, 32'h1111, 1'b0, 1'b0, "R5 conditional data written");
        rq(2'd3, 32'h40, 32'h9999, 32'h0, 1'b0, 1'b0, "R6 passed conditional disarms");

        rq(2'd2, 32'h40, 32'h0, 32'h1111, 1'b0, 1'b0, "R4 link");
        rq(2'd3, 32'h4C, 32'h2222, 32'h0, 1'b1, 1'b1, "R4 same line other word");

        rq(2'd2, 32'h40, 32'h0, 32'h1111, 1'b0, 1'b0, "R4 link");
        rq(2'd3, 32'h80, 32'h9999, 32'h0, 1'b0, 1'b0, "R5 other line fails");
        rq(2'd3, 32'h40, 32'h9999, 32'h0, 1'b0, 1'b0, "R6 failed conditional disarms");

        rq(2'd2, 32'h40, 32'h0, 32'h1111, 1'b0, 1'b0, "R4 link");
        idle_snoop(2'b01, 32'h80, 1'b0, '0, "R7 snoop other line");
        rq(2'd0, 32'h48, 32'h0, 32'h5555, 1'b0, 1'b0, "R11 interleaved load");
        rq(2'd1, 32'h84, 32'h3333, 32'h0, 1'b0, 1'b1, "R11 interleaved store");
        rq(2'd1, 32'h44, 32'h4444, 32'h0, 1'b0, 1'b1, "R3 own store to reserved line");
        rq(2'd3, 32'h40, 32'h6666, 32'h0, 1'b1, 1'b1, "R7 R3 reservation survives");

        rq(2'd2, 32'h40, 32'h0, 32'h6666, 1'b0, 1'b0, "R4 link");
        idle_snoop(2'b10, 32'h48, 1'b0, '0, "R7 snoop channel 1 same line");
        rq(2'd3, 32'h40, 32'h9999, 32'h0, 1'b0, 1'b0, "R7 snooped write kills");

        rq(2'd2, 32'h40, 32'h0, 32'h6666, 1'b0, 1'b0, "R4 link");
        idle_snoop(2'b00, '0, 1'b1, 32'h4C, "R8 evict same line");
        rq(2'd3, 32'h40, 32'h9999, 32'h0, 1'b0, 1'b0, "R8 eviction kills");

        rq(2'd2, 32'h40, 32'h0, 32'h6666, 1'b0, 1'b0, "R4 link");
        idle_snoop(2'b00, '0, 1'b1, 32'h80, "R8 evict other line");
        rq(2'd3, 32'h40, 32'h7777, 32'h0, 1'b1, 1'b1, "R8 other eviction harmless");

        rq(2'd2, 32'h40, 32'h0, 32'h7777, 1'b0, 1'b0, "R4 link");
        step(1'b1, 2'd3, 32'h40, 32'h9999, 2'b01, 32'h44, 1'b0, '0,
             32'h0, 1'b0, 1'b0, "R9 snoop races conditional");
        rq(2'd2, 32'h40, 32'h0, 32'h7777, 1'b0, 1'b0, "R4 link");
        step(1'b1, 2'd3, 32'h40, 32'h9999, 2'b00, '0, 1'b1, 32'h40,
             32'h0, 1'b0, 1'b0, "R9 eviction races conditional");

        step(1'b1, 2'd2, 32'h40, 32'h0, 2'b10, 32'h40, 1'b0, '0,
             32'h7777, 1'b0, 1'b0, "R10 link data under race");
        rq(2'd3, 32'h40, 32'h9999, 32'h0, 1'b0, 1'b0, "R10 raced link arms nothing");

        rq(2'd2, 32'h40, 32'h0, 32'h7777, 1'b0, 1'b0, "R4 link first");
        rq(2'd2, 32'h80, 32'h0, 32'h1020, 1'b0, 1'b0, "R4 link second");
        rq(2'd3, 32'h40, 32'h9999, 32'h0, 1'b0, 1'b0, "R4 old reservation replaced");
        rq(2'd2, 32'h40, 32'h0, 32'h7777, 1'b0, 1'b0, "R4 link first");
        rq(2'd2, 32'h80, 32'h0, 32'h1020, 1'b0, 1'b0, "R4 link second");
        rq(2'd3, 32'h80, 32'h8888, 32'h0, 1'b1, 1'b1, "R4 newest reservation holds");
        rq(2'd0, 32'h80, 32'h0, 32'h8888, 1'b0, 1'b0, "R5 written through");
        rq(2'd0, 32'h40, 32'h0, 32'h7777, 1'b0, 1'b0, "R9 raced stores left no trace");

        step(1'b0, 2'd0, '0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0, "R2 idle");
        repeat (3) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: got %0d responses missing, expected 0", sb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule